// File: doc/BRIEF.md
# Banked Register File Decoder

This block is the data-side register file of a small 8-bit core. Each access carries a 7-bit in-bank address. A one-bit bank selector completes it. The bank selector is taken from the block's own status register, or from bit 7 of the file pointer when the access is indirect. The block sorts the resulting location into one of three regions. The low 32 locations of each bank are special-function registers. Locations 20h to 5Fh are a 64-byte general-purpose RAM, and both banks see the same bytes there. Locations 60h to 7Fh are empty.

Two special-function registers live inside the block: the status register, which carries the bank bit, and the file pointer. Every other special-function location is passed out on a select strobe, with its 5-bit offset, its bank, the write data and a write enable. An external block owns those registers and returns their read value. Reads come straight from the decoded location with no clock delay. Writes take effect on the rising clock edge.

Top module: `rfd_banked_regfile`

## Requirements
- R1: After reset the bank bit is 0 and the file pointer holds 00h.
- R2: The status register sits at in-bank offset 03h in both banks. Its bit 5 is the bank bit, and a write updates only that bit. A read returns the bank bit in bit 5 and 0 in every other bit, so bits 7:6 read 0 even after a write of ones.
- R3: In-bank locations 00h to 1Fh, other than 03h and 04h, raise `sfr_sel` in the same cycle. `sfr_addr` carries the low 5 address bits and `sfr_bank` carries the effective bank. `sfr_we` follows `acc_we`, and `acc_rdata` returns `sfr_rdata`. Such an access never writes the RAM.
- R4: In-bank locations 20h to 5Fh address RAM byte (location - 20h), and bank 0 and bank 1 reach the same byte.
- R5: In-bank locations 60h to 7Fh read as 00h and leave `sfr_sel` low. Writes to them change no RAM byte or register.
- R6: When `acc_indirect` is 1, the effective address is the pointer's bits 6:0 and the effective bank is the pointer's bit 7. In that case `acc_addr` and the status bank bit are ignored.
- R7: `acc_rdata` follows a change of address in the same cycle without a clock edge. Storage changes only at a rising clock edge with `acc_we` high.
- R8: The file pointer sits at in-bank offset 04h in both banks. It is read and written as 8 bits. Accesses to offsets 03h and 04h are served inside the block and leave `sfr_sel` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_addr | input | 7 | Direct in-bank address |
| acc_indirect | input | 1 | 1 selects addressing through the file pointer |
| acc_we | input | 1 | Write enable for the current access |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data of the decoded location |
| sfr_sel | output | 1 | External special-function register selected |
| sfr_bank | output | 1 | Effective bank of the access |
| sfr_addr | output | 5 | Offset inside the special-function region |
| sfr_we | output | 1 | Write strobe towards the external registers |
| sfr_wdata | output | 8 | Write data towards the external registers |
| sfr_rdata | input | 8 | Read data from the external registers |

## Verification
The bench writes a RAM byte in one bank and reads it back from the other. A decoder that folded the bank into the RAM index would return a different byte. It writes to 60h and then checks RAM byte 00h, because a 6-bit index that wrapped would land on that byte. It also writes to special-function offset 05h and checks RAM byte 05h, which catches a RAM write that is not gated by region. It writes all ones to the status register and expects 20h back, so a design that stored the reserved bits is caught. Indirect accesses use a pointer whose bit 7 differs from the status bank bit, which shows a design that takes the bank from the wrong source.

// File: rtl/rfd_pkg.sv
package rfd_pkg;

  typedef enum logic [1:0] {
    RG_SFR  = 2'd0,
    RG_GPR  = 2'd1,
    RG_NONE = 2'd2
  } region_e;

  // Sort an in-bank location into its region.
  function automatic region_e classify(input int unsigned loc,
                                       input int unsigned sfr_span,
                                       input int unsigned gpr_base,
                                       input int unsigned gpr_depth);
    if (loc < sfr_span)
      return RG_SFR;
    else if (loc >= gpr_base && loc < gpr_base + gpr_depth)
      return RG_GPR;
    else
      return RG_NONE;
  endfunction

  // RAM byte index for a location inside the general-purpose window.
  function automatic int unsigned gpr_offset(input int unsigned loc,
                                             input int unsigned gpr_base);
    return loc - gpr_base;
  endfunction

endpackage

// File: rtl/rfd_addr_mux.sv
module rfd_addr_mux #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              indirect,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic              dir_bank,
  input  logic [DATA_W-1:0] ptr,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              eff_bank
);
  always_comb begin
    if (indirect) begin
      eff_addr = ptr[ADDR_W-1:0];
      eff_bank = ptr[DATA_W-1];
    end else begin
      eff_addr = dir_addr;
      eff_bank = dir_bank;
    end
  end
endmodule

// File: rtl/rfd_region_decode.sv
module rfd_region_decode
  import rfd_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int SFR_SPAN  = 32,
  parameter int GPR_BASE  = 32,
  parameter int GPR_DEPTH = 64,
  localparam int SFR_W    = $clog2(SFR_SPAN),
  localparam int GPR_IW   = $clog2(GPR_DEPTH)
) (
  input  logic [ADDR_W-1:0] loc,
  output region_e           region,
  output logic [SFR_W-1:0]  sfr_off,
  output logic [GPR_IW-1:0] gpr_idx
);
  always_comb begin
    region  = classify(int'(loc), SFR_SPAN, GPR_BASE, GPR_DEPTH);
    sfr_off = loc[SFR_W-1:0];
    gpr_idx = GPR_IW'(gpr_offset(int'(loc), GPR_BASE));
  end
endmodule

// File: rtl/rfd_core_regs.sv
module rfd_core_regs #(
  parameter int DATA_W   = 8,
  parameter int BANK_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic              ptr_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              bank_q,
  output logic [DATA_W-1:0] ptr_q,
  output logic [DATA_W-1:0] stat_view
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      if (stat_wr) bank_q <= wdata[BANK_BIT];
      if (ptr_wr)  ptr_q  <= wdata;
    end
  end

  // Only the bank bit is held; reserved and unowned bits read 0.
  always_comb begin
    stat_view           = '0;
    stat_view[BANK_BIT] = bank_q;
  end
endmodule

// File: rtl/rfd_gpr_ram.sv
module rfd_gpr_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/rfd_banked_regfile.sv
module rfd_banked_regfile
  import rfd_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SFR_SPAN  = 32,
  parameter int GPR_BASE  = 32,
  parameter int GPR_DEPTH = 64,
  parameter int BANK_BIT  = 5,
  parameter int STAT_OFF  = 3,
  parameter int PTR_OFF   = 4,
  localparam int ADDR_W   = DATA_W - 1,
  localparam int SFR_W    = $clog2(SFR_SPAN),
  localparam int GPR_IW   = $clog2(GPR_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_indirect,
  input  logic              acc_we,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              sfr_sel,
  output logic              sfr_bank,
  output logic [SFR_W-1:0]  sfr_addr,
  output logic              sfr_we,
  output logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] sfr_rdata
);
  logic [ADDR_W-1:0] eff_addr;
  logic              eff_bank;
  logic              bank_q;
  logic [DATA_W-1:0] ptr_q;
  logic [DATA_W-1:0] stat_view;
  logic [DATA_W-1:0] gpr_rdata;
  region_e           region;
  logic [SFR_W-1:0]  sfr_off;
  logic [GPR_IW-1:0] gpr_idx;

  // Named events for the checker.
  logic ev_stat_hit, ev_ptr_hit, ev_unimpl, ev_gpr_wr, ev_stat_wr, ev_ptr_wr;

  rfd_addr_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
    .indirect (acc_indirect),
    .dir_addr (acc_addr),
    .dir_bank (bank_q),
    .ptr      (ptr_q),
    .eff_addr (eff_addr),
    .eff_bank (eff_bank)
  );

  rfd_region_decode #(
    .ADDR_W(ADDR_W), .SFR_SPAN(SFR_SPAN),
    .GPR_BASE(GPR_BASE), .GPR_DEPTH(GPR_DEPTH)
  ) u_dec (
    .loc     (eff_addr),
    .region  (region),
    .sfr_off (sfr_off),
    .gpr_idx (gpr_idx)
  );

  always_comb begin
    ev_stat_hit = (region == RG_SFR) && (sfr_off == SFR_W'(STAT_OFF));
    ev_ptr_hit  = (region == RG_SFR) && (sfr_off == SFR_W'(PTR_OFF));
    ev_unimpl   = (region == RG_NONE);
    ev_gpr_wr   = acc_we && (region == RG_GPR);
    ev_stat_wr  = acc_we && ev_stat_hit;
    ev_ptr_wr   = acc_we && ev_ptr_hit;
  end

  rfd_core_regs #(.DATA_W(DATA_W), .BANK_BIT(BANK_BIT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_wr   (ev_stat_wr),
    .ptr_wr    (ev_ptr_wr),
    .wdata     (acc_wdata),
    .bank_q    (bank_q),
    .ptr_q     (ptr_q),
    .stat_view (stat_view)
  );

  rfd_gpr_ram #(.DATA_W(DATA_W), .DEPTH(GPR_DEPTH)) u_ram (
    .clk   (clk),
    .we    (ev_gpr_wr),
    .idx   (gpr_idx),
    .wdata (acc_wdata),
    .rdata (gpr_rdata)
  );

  assign sfr_sel   = (region == RG_SFR) && !ev_stat_hit && !ev_ptr_hit;
  assign sfr_bank  = eff_bank;
  assign sfr_addr  = sfr_off;
  assign sfr_we    = acc_we && sfr_sel;
  assign sfr_wdata = acc_wdata;

  always_comb begin
    if (ev_stat_hit)              acc_rdata = stat_view;
    else if (ev_ptr_hit)          acc_rdata = ptr_q;
    else if (sfr_sel)             acc_rdata = sfr_rdata;
    else if (region == RG_GPR)    acc_rdata = gpr_rdata;
    else                          acc_rdata = '0;
  end
endmodule

// File: rtl/rfd_checker.sv
module rfd_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_indirect,
  input logic [DATA_W-1:0] acc_rdata,
  input logic              sfr_sel,
  input logic              sfr_bank,
  input logic              bank_q,
  input logic [DATA_W-1:0] ptr_q,
  input logic              ev_stat_hit,
  input logic              ev_unimpl,
  input logic              ev_gpr_wr,
  input logic              ev_stat_wr,
  input logic              ev_ptr_wr
);
  p_unimpl_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unimpl |-> (acc_rdata == '0) && !sfr_sel && !ev_gpr_wr);

  p_sfr_spares_ram_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_sel |-> !ev_gpr_wr);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stat_hit |-> (acc_rdata[DATA_W-1 -: 2] == 2'b00));

  p_bank_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_stat_wr |=> $stable(bank_q));

  p_ptr_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ptr_wr |=> $stable(ptr_q));

  p_indirect_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_indirect && sfr_sel) |-> (sfr_bank == ptr_q[DATA_W-1]));

  p_direct_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_indirect && sfr_sel) |-> (sfr_bank == bank_q));
endmodule

bind rfd_banked_regfile rfd_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_indirect (acc_indirect),
  .acc_rdata    (acc_rdata),
  .sfr_sel      (sfr_sel),
  .sfr_bank     (sfr_bank),
  .bank_q       (bank_q),
  .ptr_q        (ptr_q),
  .ev_stat_hit  (ev_stat_hit),
  .ev_unimpl    (ev_unimpl),
  .ev_gpr_wr    (ev_gpr_wr),
  .ev_stat_wr   (ev_stat_wr),
  .ev_ptr_wr    (ev_ptr_wr)
);

// File: tb/rfd_banked_regfile_test.sv
module rfd_banked_regfile_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] acc_addr = '0;
  logic       acc_indirect = 1'b0;
  logic       acc_we = 1'b0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic       sfr_sel, sfr_bank, sfr_we;
  logic [4:0] sfr_addr;
  logic [7:0] sfr_wdata, sfr_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // External register model: value tells bank and offset apart.
  assign sfr_rdata = {sfr_bank, 2'b10, sfr_addr};

  rfd_banked_regfile uut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_indirect(acc_indirect),
    .acc_we(acc_we), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .sfr_sel(sfr_sel), .sfr_bank(sfr_bank), .sfr_addr(sfr_addr),
    .sfr_we(sfr_we), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic ind, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_indirect = ind; acc_addr = a; acc_wdata = d; acc_we = 1'b1;
    @(posedge clk);
    #1 acc_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic ind, input logic [6:0] a,
                        input logic [7:0] exp);
    @(negedge clk);
    acc_indirect = ind; acc_addr = a; acc_we = 1'b0;
    #1 chk(tag, acc_rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 status after reset", 1'b0, 7'h03, 8'h00);
    rd_chk("R1 pointer after reset", 1'b0, 7'h04, 8'h00);
  endtask

  task automatic t_status;
    wr(1'b0, 7'h03, 8'hFF);
    rd_chk("R2 status keeps only bank bit", 1'b0, 7'h03, 8'h20);
    rd_chk("R2 status seen from bank 1", 1'b0, 7'h03, 8'h20);
    wr(1'b0, 7'h03, 8'hDF);
    rd_chk("R2 bank bit cleared", 1'b0, 7'h03, 8'h00);
  endtask

  task automatic t_gpr;
    wr(1'b0, 7'h20, 8'hA5);
    wr(1'b0, 7'h5F, 8'h3C);
    wr(1'b0, 7'h03, 8'h20);
    rd_chk("R4 byte 20h mirrored in bank 1", 1'b0, 7'h20, 8'hA5);
    rd_chk("R4 byte 5Fh mirrored in bank 1", 1'b0, 7'h5F, 8'h3C);
    wr(1'b0, 7'h45, 8'h77);
    wr(1'b0, 7'h03, 8'h00);
    rd_chk("R4 bank 1 write seen in bank 0", 1'b0, 7'h45, 8'h77);
  endtask

  task automatic t_unimpl;
    wr(1'b0, 7'h60, 8'hFF);
    rd_chk("R5 60h reads zero", 1'b0, 7'h60, 8'h00);
    chk("R5 60h no sfr_sel", sfr_sel, 0);
    rd_chk("R5 7Fh reads zero", 1'b0, 7'h7F, 8'h00);
    rd_chk("R5 write to 60h left RAM byte 0", 1'b0, 7'h20, 8'hA5);
  endtask

  task automatic t_sfr;
    wr(1'b0, 7'h25, 8'h11);
    @(negedge clk);
    acc_indirect = 1'b0; acc_addr = 7'h05; acc_wdata = 8'hEE; acc_we = 1'b1;
    #1;
    chk("R3 sfr_sel on 05h", sfr_sel, 1);
    chk("R3 sfr_addr", sfr_addr, 5);
    chk("R3 sfr_we", sfr_we, 1);
    chk("R3 sfr_wdata", sfr_wdata, 8'hEE);
    chk("R3 read from external", acc_rdata, 8'h45);
    @(posedge clk);
    #1 acc_we = 1'b0;
    rd_chk("R3 RAM byte 05h untouched", 1'b0, 7'h25, 8'h11);
    wr(1'b0, 7'h03, 8'h20);
    rd_chk("R3 bank 1 offset 1Fh", 1'b0, 7'h1F, 8'hDF);
    chk("R3 sfr_bank follows status", sfr_bank, 1);
    wr(1'b0, 7'h03, 8'h00);
    rd_chk("R8 status no sfr_sel", 1'b0, 7'h03, 8'h00);
    chk("R8 status served locally", sfr_sel, 0);
  endtask

  task automatic t_indirect;
    wr(1'b0, 7'h21, 8'h5A);
    wr(1'b0, 7'h04, 8'hA1);
    rd_chk("R8 pointer full 8 bits", 1'b0, 7'h04, 8'hA1);
    rd_chk("R6 indirect RAM via bank 1 pointer", 1'b1, 7'h7F, 8'h5A);
    wr(1'b0, 7'h04, 8'h85);
    rd_chk("R6 indirect sfr read", 1'b1, 7'h00, 8'hC5);
    chk("R6 indirect bank from pointer", sfr_bank, 1);
    wr(1'b0, 7'h04, 8'h70);
    wr(1'b1, 7'h21, 8'hFF);
    rd_chk("R6 indirect unimpl reads zero", 1'b1, 7'h21, 8'h00);
    rd_chk("R5 indirect unimpl write ignored", 1'b0, 7'h21, 8'h5A);
    wr(1'b0, 7'h04, 8'h83);
    wr(1'b1, 7'h00, 8'hFF);
    rd_chk("R6 indirect status write", 1'b0, 7'h03, 8'h20);
    wr(1'b0, 7'h04, 8'h04);
    wr(1'b1, 7'h00, 8'h22);
    rd_chk("R8 pointer written indirectly", 1'b0, 7'h04, 8'h22);
    wr(1'b0, 7'h03, 8'h00);
  endtask

  task automatic t_timing;
    wr(1'b0, 7'h30, 8'h9C);
    @(negedge clk);
    acc_indirect = 1'b0; acc_addr = 7'h30; acc_wdata = 8'h00; acc_we = 1'b0;
    #1 chk("R7 combinational read", acc_rdata, 8'h9C);
    acc_addr = 7'h20;
    #1 chk("R7 read follows address", acc_rdata, 8'hA5);
    acc_addr = 7'h30;
    @(posedge clk);
    #1 chk("R7 no write without enable", acc_rdata, 8'h9C);
    acc_we = 1'b1; acc_wdata = 8'h61;
    #0.5 chk("R7 no write before edge", acc_rdata, 8'h9C);
    @(posedge clk);
    #1 acc_we = 1'b0;
    chk("R7 write at edge", acc_rdata, 8'h61);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_status();
    t_gpr();
    t_unimpl();
    t_sfr();
    t_indirect();
    t_timing();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule